// File: doc/BRIEF.md
# Eight-bit Arithmetic and Logic Unit with Status Flags

This block is the arithmetic core of a small accumulator-style processor datapath. Each cycle it takes two operands, an operation code and the current status byte. From these it produces a result, an updated status byte and a write enable that says whether the result should be written back to a register.

The unit is purely combinational. There is no handshake: a new operation can be presented every cycle, and the outputs follow the inputs within the same cycle. There is therefore no back-pressure to manage. The caller samples the outputs in the cycle it drives the inputs.

Each operation changes only its own fixed subset of the negative (N), overflow (V), zero (Z) and carry (C) flags. Every other status bit passes through untouched. Compare and bit test exist only for their flags, so they leave the write enable low. Decimal-mode arithmetic is not provided.

Top module: `flag_alu`

## Requirements
- R1: Status bits are placed as C at bit 0, Z at bit 1, V at bit 6 and N at bit 7. Bits 2 to 5 of `status_out` always equal those of `status_in`.
- R2: Code 0 (add) gives result = A + B + C mod 256. C is the ninth sum bit. V is set when A and B share a sign bit that differs from the result's. N is result bit 7 and Z is (result == 0).
- R3: Code 1 (subtract) gives result = A + ~B + C mod 256, with C = 1 meaning "no borrow". N, V, Z and C are formed as in R2, using ~B as the second operand.
- R4: Codes 2 (AND), 3 (OR) and 4 (XOR) combine A with B bitwise. They update N and Z from the result and leave V and C unchanged.
- R5: Code 5 shifts A left, with old bit 7 going into C and 0 into bit 0. Code 6 shifts A right, with old bit 0 going into C and 0 into bit 7, so N ends up 0. Both update N, Z and C and leave V unchanged.
- R6: Code 7 rotates left through carry: new C = A[7] and result = {A[6:0], old C}. Code 8 rotates right through carry: new C = A[0] and result = {old C, A[7:1]}. Both update N, Z and C and leave V unchanged.
- R7: Codes 9 and 10 give A + 1 and A - 1 modulo 256, wrapping at the ends. They update N and Z only; C and V are unchanged.
- R8: Code 11 (compare) sets C = (A >= B, unsigned), Z = (A == B) and N = bit 7 of (A - B) mod 256. It leaves V unchanged and drives `result_we` low.
- R9: Code 12 (bit test) sets Z = ((A & B) == 0), N = B[7] and V = B[6]. It leaves C unchanged, presents A & B on `result` and drives `result_we` low.
- R10: Codes 13 to 15 are unused. For these, `result` equals A, `status_out` equals `status_in` and `result_we` is low.
- R11: `result_we` is high for codes 0 to 10 and low for all other codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | Register operand A (the only operand for shifts, rotates, increment and decrement) |
| op_b | input | 8 | Second operand B |
| op_sel | input | 4 | Operation code, 0 to 12 as listed in the requirements |
| status_in | input | 8 | Current status byte |
| result | output | 8 | Operation result |
| status_out | output | 8 | Updated status byte |
| result_we | output | 1 | High when the result should be written back |

## Verification
The hardest cases to reach from the ports are the signed-overflow cases of add and subtract and the carry-in dependence of the rotates. They need particular pairings of operand signs together with the incoming carry. The bench reaches them by sweeping A over all 256 values against a B set chosen around the sign and zero boundaries (0x00, 0x3F, 0x40, 0x7F, 0x80, 0xFF and neighbours). Each pair is run with the carry both clear and set. Each pair is also run with two status backgrounds: all flags clear, and every non-carry bit set. Run against both backgrounds, a flag that should have been left alone cannot hide by happening to match.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_V = 6;
  localparam int FL_N = 7;
  localparam int ST_W = 8;

  typedef enum logic [3:0] {
    OP_ADC = 4'd0,
    OP_SBC = 4'd1,
    OP_AND = 4'd2,
    OP_ORA = 4'd3,
    OP_EOR = 4'd4,
    OP_ASL = 4'd5,
    OP_LSR = 4'd6,
    OP_ROL = 4'd7,
    OP_ROR = 4'd8,
    OP_INC = 4'd9,
    OP_DEC = 4'd10,
    OP_CMP = 4'd11,
    OP_BIT = 4'd12
  } alu_op_e;

  // Order: n, v, z, c
  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flag4_t;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_fn_e;

endpackage

// File: rtl/flag_alu_addsub.sv
module flag_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         inv_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = inv_b ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    sum   = wide[W-1:0];
    cout  = wide[W];
    // signed overflow: equal operand signs, different result sign
    ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_fn_e    fn,
  output logic [W-1:0] res
);
  always_comb begin
    case (fn)
      LG_OR:   res = a | b;
      LG_XOR:  res = a ^ b;
      default: res = a & b;
    endcase
  end
endmodule

// File: rtl/flag_alu_shift.sv
module flag_alu_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  input  logic         left,
  input  logic         rotate,
  output logic [W-1:0] res,
  output logic         cout
);
  logic fill;

  always_comb begin
    fill = rotate ? cin : 1'b0;
    if (left) begin
      res  = {a[W-2:0], fill};
      cout = a[W-1];
    end else begin
      res  = {fill, a[W-1:1]};
      cout = a[0];
    end
  end
endmodule

// File: rtl/flag_alu_merge.sv
module flag_alu_merge
  import flag_alu_pkg::*;
(
  input  logic [ST_W-1:0] st_in,
  input  flag4_t          upd,
  input  flag4_t          val,
  output logic [ST_W-1:0] st_out
);
  localparam int NFL = 4;
  localparam int POS [NFL] = '{FL_C, FL_Z, FL_V, FL_N};

  logic [NFL-1:0] upd_v;
  logic [NFL-1:0] val_v;

  always_comb begin
    upd_v  = {upd.n, upd.v, upd.z, upd.c};
    val_v  = {val.n, val.v, val.z, val.c};
    st_out = st_in;
    for (int i = 0; i < NFL; i++) begin
      if (upd_v[i]) st_out[POS[i]] = val_v[i];
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  input  logic [3:0]      op_sel,
  input  logic [ST_W-1:0] status_in,
  output logic [W-1:0]    result,
  output logic [ST_W-1:0] status_out,
  output logic            result_we
);
  localparam logic [W-1:0] ZERO = '0;

  alu_op_e   op;
  logic      c_in;

  logic [W-1:0] as_b;
  logic         as_inv;
  logic         as_cin;
  logic [W-1:0] as_sum;
  logic         as_cout;
  logic         as_ovf;

  logic_fn_e    lg_fn;
  logic [W-1:0] lg_res;

  logic         sh_left;
  logic         sh_rot;
  logic [W-1:0] sh_res;
  logic         sh_cout;

  flag4_t upd;
  flag4_t val;

  assign op   = alu_op_e'(op_sel);
  assign c_in = status_in[FL_C];

  // operand steering for the shared adder
  always_comb begin
    as_b   = op_b;
    as_inv = 1'b0;
    as_cin = c_in;
    case (op)
      OP_SBC: as_inv = 1'b1;
      OP_CMP: begin as_inv = 1'b1; as_cin = 1'b1; end
      OP_INC: begin as_b = ZERO;  as_cin = 1'b1; end
      OP_DEC: begin as_b = ~ZERO; as_cin = 1'b0; end
      default: ;
    endcase
  end

  always_comb begin
    case (op)
      OP_ORA:  lg_fn = LG_OR;
      OP_EOR:  lg_fn = LG_XOR;
      default: lg_fn = LG_AND;
    endcase
    sh_left = (op == OP_ASL) || (op == OP_ROL);
    sh_rot  = (op == OP_ROL) || (op == OP_ROR);
  end

  flag_alu_addsub #(.W(W)) u_addsub (
    .a(op_a), .b(as_b), .inv_b(as_inv), .cin(as_cin),
    .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
  );

  flag_alu_logic #(.W(W)) u_logic (
    .a(op_a), .b(op_b), .fn(lg_fn), .res(lg_res)
  );

  flag_alu_shift #(.W(W)) u_shift (
    .a(op_a), .cin(c_in), .left(sh_left), .rotate(sh_rot),
    .res(sh_res), .cout(sh_cout)
  );

  // result select and per-operation flag subset
  always_comb begin
    result    = op_a;
    result_we = 1'b0;
    upd       = '0;
    val       = '0;
    case (op)
      OP_ADC, OP_SBC: begin
        result    = as_sum;
        result_we = 1'b1;
        upd       = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
        val       = '{n: as_sum[W-1], v: as_ovf, z: (as_sum == ZERO), c: as_cout};
      end
      OP_AND, OP_ORA, OP_EOR: begin
        result    = lg_res;
        result_we = 1'b1;
        upd       = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
        val       = '{n: lg_res[W-1], v: 1'b0, z: (lg_res == ZERO), c: 1'b0};
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        result    = sh_res;
        result_we = 1'b1;
        upd       = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
        val       = '{n: sh_res[W-1], v: 1'b0, z: (sh_res == ZERO), c: sh_cout};
      end
      OP_INC, OP_DEC: begin
        result    = as_sum;
        result_we = 1'b1;
        upd       = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
        val       = '{n: as_sum[W-1], v: 1'b0, z: (as_sum == ZERO), c: 1'b0};
      end
      OP_CMP: begin
        result    = as_sum;
        upd       = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
        val       = '{n: as_sum[W-1], v: 1'b0, z: (as_sum == ZERO), c: as_cout};
      end
      OP_BIT: begin
        result    = lg_res;
        upd       = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b0};
        val       = '{n: op_b[W-1], v: op_b[W-2], z: (lg_res == ZERO), c: 1'b0};
      end
      default: ;
    endcase
  end

  flag_alu_merge u_merge (
    .st_in(status_in), .upd(upd), .val(val), .st_out(status_out)
  );
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [3:0]   op_sel,
  input logic [7:0]   status_in,
  input logic [W-1:0] result,
  input logic [7:0]   status_out,
  input logic         result_we
);
  logic nz_only;
  logic writes;

  always_comb begin
    nz_only = (op_sel == 4'd2) || (op_sel == 4'd3) || (op_sel == 4'd4) ||
              (op_sel == 4'd9) || (op_sel == 4'd10);
    writes  = (op_sel <= 4'd10);

    assert_keep_ctrl_R1: assert (status_out[5:2] == status_in[5:2])
      else $error("control bits changed");
    assert_we_map_R11: assert (result_we == writes)
      else $error("write enable mismatch");
    assert_z_tracks_R2: assert (!writes || (status_out[1] == (result == '0)))
      else $error("Z not matching written result");
    assert_vc_hold_R4: assert (!nz_only || (status_out[6] == status_in[6] &&
                                            status_out[0] == status_in[0]))
      else $error("V or C touched by N/Z-only op");
    assert_lsr_n_clear_R5: assert (op_sel != 4'd6 || !status_out[7])
      else $error("N set after right shift");
    assert_cmp_carry_R8: assert (op_sel != 4'd11 || (status_out[0] == (op_a >= op_b)))
      else $error("compare carry wrong");
    assert_unused_R10: assert (op_sel <= 4'd12 ||
                               (status_out == status_in && result == op_a))
      else $error("unused code changed state");
  end
endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_flag_alu_chk (
  .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .status_in(status_in),
  .result(result), .status_out(status_out), .result_we(result_we)
);

// File: tb/flag_alu_test.sv
module flag_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] op_a = '0;
  logic [7:0] op_b = '0;
  logic [3:0] op_sel = '0;
  logic [7:0] status_in = '0;
  logic [7:0] result;
  logic [7:0] status_out;
  logic       result_we;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flag_alu uut (
    .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .status_in(status_in),
    .result(result), .status_out(status_out), .result_we(result_we)
  );

  function automatic string req_of(input int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2, 3, 4: return "R4";
      5, 6: return "R5";
      7, 8: return "R6";
      9, 10: return "R7";
      11: return "R8";
      12: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [7:0] pick_b(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h3F;
      3: return 8'h40;
      4: return 8'h7F;
      5: return 8'h80;
      6: return 8'h81;
      7: return 8'hC3;
      8: return 8'hFE;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s op=%0d a=%02h b=%02h st=%02h actual=%0h expected=%0h",
               req, what, op_sel, op_a, op_b, status_in, act, exp);
    end
  endtask

  task automatic run_one(input int op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] st);
    logic [8:0] w;
    logic [7:0] b2;
    logic [7:0] r;
    logic [7:0] s;
    logic       we;
    logic       c;
    c  = st[0];
    r  = a;
    s  = st;
    we = 1'b0;
    case (op)
      0, 1: begin // R2 add, R3 subtract with inverted borrow
        b2 = (op == 1) ? ~b : b;
        w  = {1'b0, a} + {1'b0, b2} + {8'd0, c};
        r  = w[7:0];
        s[0] = w[8];
        s[6] = (a[7] == b2[7]) && (r[7] != a[7]);
        s[7] = r[7]; s[1] = (r == 8'h00); we = 1'b1;
      end
      2, 3, 4: begin // R4
        r = (op == 2) ? (a & b) : (op == 3) ? (a | b) : (a ^ b);
        s[7] = r[7]; s[1] = (r == 8'h00); we = 1'b1;
      end
      5, 6, 7, 8: begin // R5 shifts, R6 rotates
        if (op == 5 || op == 7) begin
          r = {a[6:0], (op == 7) ? c : 1'b0};
          s[0] = a[7];
        end else begin
          r = {(op == 8) ? c : 1'b0, a[7:1]};
          s[0] = a[0];
        end
        s[7] = r[7]; s[1] = (r == 8'h00); we = 1'b1;
      end
      9, 10: begin // R7
        r = (op == 9) ? a + 8'd1 : a - 8'd1;
        s[7] = r[7]; s[1] = (r == 8'h00); we = 1'b1;
      end
      11: begin // R8
        r = a - b;
        s[7] = r[7]; s[1] = (a == b); s[0] = (a >= b);
      end
      12: begin // R9
        r = a & b;
        s[7] = b[7]; s[6] = b[6]; s[1] = (r == 8'h00);
      end
      default: ; // R10: unchanged
    endcase

    op_sel = 4'(op); op_a = a; op_b = b; status_in = st;
    #1;
    check(req_of(op), "result", int'(result), int'(r));
    check(req_of(op), "status", int'(status_out), int'(s));
    check("R11", "result_we", int'(result_we), int'(we));
    check("R1", "ctrl bits", int'(status_out[5:2]), int'(st[5:2]));
    #1;
  endtask

  initial begin
    #(8 * 199000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state: add of zeros with clear status gives 0 and only Z (R2)
    #1;
    check("R2", "reset result", int'(result), 0);
    check("R2", "reset status", int'(status_out), 8'h02);
    check("R11", "reset we", int'(result_we), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner values
    run_one(0, 8'h7F, 8'h01, 8'h00); // R2 positive overflow
    run_one(0, 8'hFF, 8'h01, 8'h00); // R2 carry out, zero
    run_one(1, 8'h80, 8'h01, 8'h01); // R3 negative overflow
    run_one(1, 8'h00, 8'h01, 8'h01); // R3 borrow
    run_one(7, 8'h80, 8'h00, 8'h01); // R6 ring passes carry
    run_one(8, 8'h01, 8'h00, 8'h00); // R6 result zero, carry set
    run_one(9, 8'hFF, 8'h00, 8'h41); // R7 wrap keeps C and V
    run_one(10, 8'h00, 8'h00, 8'h00); // R7 wrap down
    run_one(11, 8'h10, 8'h10, 8'h00); // R8 equal
    run_one(12, 8'h0F, 8'hF0, 8'h01); // R9 zero with N and V from B
    run_one(14, 8'h5A, 8'hA5, 8'hC3); // R10

    // sweep: all codes, all A, boundary B, carry and background patterns
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 10; bi++) begin
          for (int sp = 0; sp < 4; sp++) begin
            logic [7:0] st;
            st = (sp[1] ? 8'hFE : 8'h00) | {7'd0, sp[0]};
            run_one(op, 8'(a), pick_b(bi), st);
          end
        end
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule